// File: doc/BRIEF.md
# Queue Condition Flags and Interrupt Source Selector

This block works next to a hardware queue manager. It watches each queue's present fill count and two thresholds, a low-water mark and a high-water mark, and turns them into four condition flags per queue. Software reads these flags through a small word-addressed register port. The same flags also drive a per-queue interrupt path. A queue can raise an event only while its enable bit is set. Each event is held in a sticky pending bit until software writes a one to clear it.

The queues fall into two groups. In the low group, each queue exposes all four flags. Each low queue also picks which condition, or its inverse, produces its event. In the high group, each queue exposes only two flags, and its event condition is fixed to the low-water flag. Each group ORs its pending bits onto its own interrupt line. The register map scales with the group sizes. Every address below assumes the default configuration: 16 low queues, 8 high queues and a queue depth of 16.

Top module: `qstat_irq_sel`

## Requirements
- R1: For a queue with count c, the flags are computed as follows. Empty is c==0. Full is c>=QDEPTH. Nearly-empty is c <= low-water mark. Nearly-full is (QDEPTH−c, or 0 when c>=QDEPTH) <= high-water mark.
- R2: A low status word at address w (0..NUM_LO/8−1) holds queue 8w+l in bits 4l+3..4l. Inside each nibble, bit 0 is empty, bit 1 is nearly-empty, bit 2 is nearly-full and bit 3 is full.
- R3: Address NUM_LO/8 returns the nearly-empty bits of the high group, and the next address returns their full bits. Bit j stands for high queue j, which is queue NUM_LO+j. Unused bits read 0.
- R4: The select words start at address NUM_LO/8+2 and use the same nibble layout as R2. In the low 3 bits, code 0/1/2/3 picks empty/nearly-empty/nearly-full/full, and 4..7 pick the inverse of 0..3. Bit 3 is stored and read back but does not affect the decode.
- R5: A write to the select word that holds queue 0 forces that queue's select bits 2..0 to 111 and leaves its bit 3 unchanged, whatever the write data is.
- R6: A queue's pending bit is set in the clock after its selected condition goes from 0 to 1 while its enable bit is set. A condition that is already true, or that rises while enable is 0, sets nothing. The low and high enable words sit at NUM_LO/8+4 and NUM_LO/8+5.
- R7: The event condition of a high-group queue is its nearly-empty flag, regardless of the select words.
- R8: The pending words sit at NUM_LO/8+6 (low) and NUM_LO/8+7 (high) and read back the pending bits. Writing a 1 clears that bit, and writing a 0 leaves it unchanged.
- R9: If a clearing write and a new event for the same queue land in the same clock, the bit stays set.
- R10: irq_lo is high exactly when some low pending bit is set, and irq_hi likewise for the high group.
- R11: Writes to the status addresses have no effect.
- R12: After reset, the select, enable and pending registers are zero and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_count | input | (NUM_LO+NUM_HI)*CNT_W | Fill count per queue, queue i at bits i*CNT_W |
| ne_mark | input | (NUM_LO+NUM_HI)*CNT_W | Low-water mark per queue |
| nf_mark | input | (NUM_LO+NUM_HI)*CNT_W | High-water mark (free entries) per queue |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_lo | output | 1 | OR of low-group pending bits |
| irq_hi | output | 1 | OR of high-group pending bits |

## Verification
A software clear of a pending word can land in the same clock as a fresh rising edge of the selected condition on one of the queues being cleared. The bench provokes this by first dropping a queue's condition. At one falling clock edge it then restores the count and issues the clearing write together, alongside a second pending queue that has no new event. The expected result is computed independently of the design: the colliding queue's bit survives, the other bit clears, and the interrupt line stays high.

// File: rtl/qsi_pkg.sv
package qsi_pkg;

    localparam int WORD_W = 32;
    localparam int NIB_W  = 4;
    localparam int LANES  = WORD_W / NIB_W;

    // bit 0 empty, bit 1 nearly-empty, bit 2 nearly-full, bit 3 full
    typedef struct packed {
        logic full;
        logic nfull;
        logic nempty;
        logic empty;
    } qflags_t;

    typedef enum logic [2:0] {
        SRC_EMPTY      = 3'd0,
        SRC_NEMPTY     = 3'd1,
        SRC_NFULL      = 3'd2,
        SRC_FULL       = 3'd3,
        SRC_NOT_EMPTY  = 3'd4,
        SRC_NOT_NEMPTY = 3'd5,
        SRC_NOT_NFULL  = 3'd6,
        SRC_NOT_FULL   = 3'd7
    } src_sel_e;

    // Low two bits index the flag, bit 2 inverts it.
    function automatic logic pick_cond(qflags_t f, logic [2:0] sel);
        logic [NIB_W-1:0] v;
        v = f;
        return v[sel[1:0]] ^ sel[2];
    endfunction

endpackage

// File: rtl/qsi_flag_unit.sv
module qsi_flag_unit
    import qsi_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] lo_mark,
    input  logic [CW-1:0] hi_mark,
    output qflags_t       flags
);

    localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);

    logic [CW-1:0] free_slots;

    always_comb begin
        free_slots   = (count >= DEPTH_V) ? '0 : (DEPTH_V - count);
        flags.empty  = (count == '0);
        flags.full   = (count >= DEPTH_V);
        flags.nempty = (count <= lo_mark);
        flags.nfull  = (free_slots <= hi_mark);
    end

endmodule

// File: rtl/qsi_pending_bank.sv
module qsi_pending_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] enable,
    input  logic         clr_valid,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] pend
);

    logic [N-1:0] cond_q;
    logic [N-1:0] rise;
    logic [N-1:0] clr_eff;

    always_comb begin
        rise    = cond & ~cond_q;
        clr_eff = clr_valid ? clr_mask : '0;
    end

    // A new event outranks a clear aimed at the same bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
            pend   <= '0;
        end else begin
            cond_q <= cond;
            pend   <= (pend & ~clr_eff) | (rise & enable);
        end
    end

    // R8: without a clearing write, no pending bit drops
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !clr_valid |=> ((pend & $past(pend)) == $past(pend)));

    // R6: a bit can only become pending while its queue is enabled
    p_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
        ((pend & ~$past(pend) & ~$past(enable)) == '0));

    // R9: an enabled rising edge survives a simultaneous clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        clr_valid |=> (($past(rise & enable) & ~pend) == '0));

endmodule

// File: rtl/qstat_irq_sel.sv
module qstat_irq_sel
    import qsi_pkg::*;
#(
    parameter int NUM_LO = 16,
    parameter int NUM_HI = 8,
    parameter int QDEPTH = 16,
    parameter int CNT_W  = $clog2(QDEPTH + 1),
    parameter int ADDR_W = 5
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [(NUM_LO+NUM_HI)*CNT_W-1:0] q_count,
    input  logic [(NUM_LO+NUM_HI)*CNT_W-1:0] ne_mark,
    input  logic [(NUM_LO+NUM_HI)*CNT_W-1:0] nf_mark,
    input  logic                             reg_wr_en,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [WORD_W-1:0]                reg_wdata,
    output logic [WORD_W-1:0]                reg_rdata,
    output logic                             irq_lo,
    output logic                             irq_hi
);

    localparam int NQ     = NUM_LO + NUM_HI;
    localparam int NLW    = NUM_LO / LANES;
    localparam int A_LST  = 0;
    localparam int A_HNE  = NLW;
    localparam int A_HF   = NLW + 1;
    localparam int A_SEL  = NLW + 2;
    localparam int A_IEL  = 2 * NLW + 2;
    localparam int A_IEH  = 2 * NLW + 3;
    localparam int A_PNL  = 2 * NLW + 4;
    localparam int A_PNH  = 2 * NLW + 5;

    qflags_t             flags  [NQ];
    logic [NIB_W-1:0]    sel_q  [NUM_LO];
    logic [NUM_LO-1:0]   ien_lo;
    logic [NUM_HI-1:0]   ien_hi;
    logic [NUM_LO-1:0]   lo_cond;
    logic [NUM_HI-1:0]   hi_cond;
    logic [NUM_LO-1:0]   pend_lo;
    logic [NUM_HI-1:0]   pend_hi;
    logic                wr_pend_lo;
    logic                wr_pend_hi;
    logic                wr_sel0;

    // ---------------- per-queue flag derivation ----------------
    for (genvar g = 0; g < NQ; g++) begin : g_flags
        qsi_flag_unit #(
            .DEPTH (QDEPTH),
            .CW    (CNT_W)
        ) u_flag (
            .count   (q_count[g*CNT_W +: CNT_W]),
            .lo_mark (ne_mark[g*CNT_W +: CNT_W]),
            .hi_mark (nf_mark[g*CNT_W +: CNT_W]),
            .flags   (flags[g])
        );
    end

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LO; i++) sel_q[i] <= '0;
            ien_lo <= '0;
            ien_hi <= '0;
        end else if (reg_wr_en) begin
            for (int i = 0; i < NUM_LO; i++) begin
                if (reg_addr == ADDR_W'(A_SEL + i / LANES)) begin
                    if (i == 0) sel_q[i][2:0] <= 3'b111;
                    else        sel_q[i] <= reg_wdata[(i % LANES) * NIB_W +: NIB_W];
                end
            end
            if (reg_addr == ADDR_W'(A_IEL)) ien_lo <= reg_wdata[NUM_LO-1:0];
            if (reg_addr == ADDR_W'(A_IEH)) ien_hi <= reg_wdata[NUM_HI-1:0];
        end
    end

    // ---------------- event conditions ----------------
    always_comb begin
        for (int i = 0; i < NUM_LO; i++) lo_cond[i] = pick_cond(flags[i], sel_q[i][2:0]);
        for (int j = 0; j < NUM_HI; j++) hi_cond[j] = flags[NUM_LO + j].nempty;
        wr_pend_lo = reg_wr_en && (reg_addr == ADDR_W'(A_PNL));
        wr_pend_hi = reg_wr_en && (reg_addr == ADDR_W'(A_PNH));
        wr_sel0    = reg_wr_en && (reg_addr == ADDR_W'(A_SEL));
    end

    qsi_pending_bank #(.N(NUM_LO)) u_pend_lo (
        .clk       (clk),
        .rst       (rst),
        .cond      (lo_cond),
        .enable    (ien_lo),
        .clr_valid (wr_pend_lo),
        .clr_mask  (reg_wdata[NUM_LO-1:0]),
        .pend      (pend_lo)
    );

    qsi_pending_bank #(.N(NUM_HI)) u_pend_hi (
        .clk       (clk),
        .rst       (rst),
        .cond      (hi_cond),
        .enable    (ien_hi),
        .clr_valid (wr_pend_hi),
        .clr_mask  (reg_wdata[NUM_HI-1:0]),
        .pend      (pend_hi)
    );

    assign irq_lo = |pend_lo;
    assign irq_hi = |pend_hi;

    // ---------------- read mux ----------------
    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NLW; w++) begin
            if (reg_addr == ADDR_W'(A_LST + w))
                for (int l = 0; l < LANES; l++) reg_rdata[l*NIB_W +: NIB_W] = flags[w*LANES + l];
            if (reg_addr == ADDR_W'(A_SEL + w))
                for (int l = 0; l < LANES; l++) reg_rdata[l*NIB_W +: NIB_W] = sel_q[w*LANES + l];
        end
        if (reg_addr == ADDR_W'(A_HNE))
            for (int j = 0; j < NUM_HI; j++) reg_rdata[j] = flags[NUM_LO + j].nempty;
        if (reg_addr == ADDR_W'(A_HF))
            for (int j = 0; j < NUM_HI; j++) reg_rdata[j] = flags[NUM_LO + j].full;
        if (reg_addr == ADDR_W'(A_IEL)) reg_rdata[NUM_LO-1:0] = ien_lo;
        if (reg_addr == ADDR_W'(A_IEH)) reg_rdata[NUM_HI-1:0] = ien_hi;
        if (reg_addr == ADDR_W'(A_PNL)) reg_rdata[NUM_LO-1:0] = pend_lo;
        if (reg_addr == ADDR_W'(A_PNH)) reg_rdata[NUM_HI-1:0] = pend_hi;
    end

    // R5: queue 0 select low bits land at 111 after a write to its word
    p_q0_low_bits_r5: assert property (@(posedge clk) disable iff (rst)
        wr_sel0 |=> (sel_q[0][2:0] == 3'b111));

    // R5: queue 0 select bit 3 is never changed by a write
    p_q0_bit3_kept_r5: assert property (@(posedge clk) disable iff (rst)
        wr_sel0 |=> (sel_q[0][3] == $past(sel_q[0][3])));

    // R1: an empty queue is always at or below its low-water mark
    p_empty_is_low_r1: assert property (@(posedge clk) disable iff (rst)
        flags[0].empty |-> flags[0].nempty);

    // R12: interrupt lines are low in the first cycle after reset
    p_quiet_after_reset_r12: assert property (@(posedge clk)
        $fell(rst) |-> (!irq_lo && !irq_hi));

endmodule

// File: tb/qstat_irq_sel_tb_top.sv
`timescale 1ns/1ps
module qstat_irq_sel_tb_top;

    localparam int NUM_LO = 16;
    localparam int NUM_HI = 8;
    localparam int QDEPTH = 16;
    localparam int CW     = 5;
    localparam int AW     = 5;
    localparam int NQ     = NUM_LO + NUM_HI;
    localparam int A_HNE  = 2;
    localparam int A_HF   = 3;
    localparam int A_SEL  = 4;
    localparam int A_IEL  = 6;
    localparam int A_IEH  = 7;
    localparam int A_PNL  = 8;
    localparam int A_PNH  = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NQ*CW-1:0]  q_count = '0;
    logic [NQ*CW-1:0]  ne_mark = '0;
    logic [NQ*CW-1:0]  nf_mark = '0;
    logic              reg_wr_en = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq_lo;
    logic              irq_hi;

    int cnt_a [NQ];
    int ne_a  [NQ];
    int nf_a  [NQ];
    logic [31:0] sh_sel [2];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    qstat_irq_sel #(
        .NUM_LO (NUM_LO),
        .NUM_HI (NUM_HI),
        .QDEPTH (QDEPTH),
        .CNT_W  (CW),
        .ADDR_W (AW)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .q_count   (q_count),
        .ne_mark   (ne_mark),
        .nf_mark   (nf_mark),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi)
    );

    function automatic logic [3:0] exp_nib(int c, int ne, int nf);
        int fr;
        logic [3:0] r;
        fr   = (c >= QDEPTH) ? 0 : QDEPTH - c;
        r[0] = (c == 0);
        r[1] = (c <= ne);
        r[2] = (fr <= nf);
        r[3] = (c >= QDEPTH);
        return r;
    endfunction

    function automatic logic exp_cond(int c, int ne, int nf, int code);
        logic [3:0] n;
        n = exp_nib(c, ne, nf);
        return n[code % 4] ^ (code >= 4);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply();
        for (int i = 0; i < NQ; i++) begin
            q_count[i*CW +: CW] = CW'(cnt_a[i]);
            ne_mark[i*CW +: CW] = CW'(ne_a[i]);
            nf_mark[i*CW +: CW] = CW'(nf_a[i]);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = AW'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(int a, logic [31:0] exp, string req);
        reg_addr = AW'(a);
        #1;
        check(req, reg_rdata, exp);
    endtask

    function automatic logic [31:0] exp_lo_word(int w);
        logic [31:0] r;
        for (int l = 0; l < 8; l++) r[l*4 +: 4] = exp_nib(cnt_a[w*8+l], ne_a[w*8+l], nf_a[w*8+l]);
        return r;
    endfunction

    function automatic logic [31:0] exp_hi_word(bit full_sel);
        logic [31:0] r;
        logic [3:0] n;
        r = '0;
        for (int j = 0; j < NUM_HI; j++) begin
            n = exp_nib(cnt_a[NUM_LO+j], ne_a[NUM_LO+j], nf_a[NUM_LO+j]);
            r[j] = full_sel ? n[3] : n[1];
        end
        return r;
    endfunction

    task automatic write_sel(int w);
        logic [31:0] e;
        wr(A_SEL + w, sh_sel[w]);
        e = sh_sel[w];
        if (w == 0) e[3:0] = 4'h7;
        rd(A_SEL + w, e, "R4 select readback");
    endtask

    initial begin
        int pa [5] = '{0, 5, 16, 3, 4};
        int pb [5] = '{5, 0, 5, 4, 3};
        for (int i = 0; i < NQ; i++) begin cnt_a[i] = 0; ne_a[i] = 0; nf_a[i] = 0; end
        sh_sel[0] = '0; sh_sel[1] = '0;
        apply();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        rd(0, 32'h33333333, "R12 low status after reset");
        rd(A_HNE, 32'h000000ff, "R12 high ne after reset");
        rd(A_HF, 32'h0, "R12 high full after reset");
        for (int a = A_SEL; a <= A_PNH; a++) rd(a, 32'h0, "R12 register zero after reset");
        check("R12 irq_lo after reset", {31'b0, irq_lo}, 32'h0);
        check("R12 irq_hi after reset", {31'b0, irq_hi}, 32'h0);

        // R1/R2/R3: flag sweep over counts and marks
        for (int c = 0; c <= QDEPTH; c++) begin
            for (int m = 0; m <= QDEPTH; m++) begin
                for (int i = 0; i < NQ; i++) begin
                    cnt_a[i] = (c + i) % (QDEPTH + 1);
                    ne_a[i]  = m;
                    nf_a[i]  = (m + 3 * i) % (QDEPTH + 1);
                end
                apply();
                rd(0, exp_lo_word(0), "R1 R2 low status word 0");
                rd(1, exp_lo_word(1), "R1 R2 low status word 1");
                rd(A_HNE, exp_hi_word(0), "R3 high ne word");
                rd(A_HF, exp_hi_word(1), "R3 high full word");
            end
        end

        // R11: status addresses ignore writes
        wr(0, 32'hffffffff);
        wr(A_HNE, 32'hffffffff);
        wr(A_HF, 32'h0);
        rd(0, exp_lo_word(0), "R11 status word after write");
        rd(A_HNE, exp_hi_word(0), "R11 high ne after write");
        rd(A_HF, exp_hi_word(1), "R11 high full after write");

        // R4/R6: select decode and rising-edge capture, per queue and code
        for (int i = 0; i < NQ; i++) begin cnt_a[i] = 5; ne_a[i] = 3; nf_a[i] = 12; end
        apply();
        for (int q = 1; q < NUM_LO; q++) begin
            for (int code = 0; code < 8; code++) begin
                sh_sel[q/8][(q%8)*4 +: 4] = 4'(code);
                write_sel(q / 8);
                for (int p = 0; p < 5; p++) begin
                    bit en;
                    logic exp_set;
                    en = ((code + p + q) % 3) != 0;
                    wr(A_IEL, en ? (32'h1 << q) : 32'h0);
                    cnt_a[q] = pa[p]; apply(); tick();
                    wr(A_PNL, 32'hffffffff);
                    cnt_a[q] = pb[p]; apply(); tick();
                    exp_set = en && exp_cond(pb[p], 3, 12, code) && !exp_cond(pa[p], 3, 12, code);
                    rd(A_PNL, exp_set ? (32'h1 << q) : 32'h0, "R6 pending after edge");
                    check("R10 irq_lo follows pending", {31'b0, irq_lo}, {31'b0, exp_set});
                end
                cnt_a[q] = 5; apply();
            end
            sh_sel[q/8][(q%8)*4 +: 4] = 4'h0;
            write_sel(q / 8);
        end

        // R4: bit 3 stored but ignored for decode (queue 5, code 9 behaves as nearly-empty)
        sh_sel[0][23:20] = 4'h9;
        write_sel(0);
        wr(A_IEL, 32'h20);
        cnt_a[5] = 10; apply(); tick();
        wr(A_PNL, 32'hffffffff);
        cnt_a[5] = 2; apply(); tick();
        rd(A_PNL, 32'h20, "R4 bit3 ignored in decode");
        sh_sel[0][23:20] = 4'h0;
        write_sel(0);

        // R6: a condition already true when enable turns on does not fire
        wr(A_IEL, 32'h0);
        cnt_a[1] = 0; apply(); tick();
        wr(A_PNL, 32'hffffffff);
        wr(A_IEL, 32'h2);
        tick(); tick();
        rd(A_PNL, 32'h0, "R6 level-true at enable does not fire");

        // R5: queue 0 select forced to 111 and bit 3 kept
        wr(A_SEL, 32'h00000008);
        rd(A_SEL, 32'h00000007, "R5 queue0 select forced");
        wr(A_IEL, 32'h1);
        cnt_a[0] = 16; apply(); tick();
        wr(A_PNL, 32'hffffffff);
        cnt_a[0] = 15; apply(); tick();
        rd(A_PNL, 32'h1, "R5 queue0 fires on not-full");
        wr(A_PNL, 32'hffffffff);
        cnt_a[0] = 5; apply(); tick();

        // R8/R9/R10: W1C, write-zero, and clear colliding with a new event
        sh_sel[0] = '0; write_sel(0);
        wr(A_IEL, 32'h18);
        cnt_a[3] = 5; cnt_a[4] = 5; apply(); tick();
        wr(A_PNL, 32'hffffffff);
        cnt_a[3] = 0; cnt_a[4] = 0; apply(); tick();
        rd(A_PNL, 32'h18, "R6 two queues pending");
        wr(A_PNL, 32'h0);
        rd(A_PNL, 32'h18, "R8 writing zero keeps pending");
        wr(A_PNL, 32'h10);
        rd(A_PNL, 32'h08, "R8 one bit cleared");
        wr(A_PNL, 32'h08);
        cnt_a[4] = 0; apply();
        cnt_a[3] = 5; apply(); tick();
        cnt_a[4] = 5; apply(); tick();
        cnt_a[4] = 0; apply(); tick();
        rd(A_PNL, 32'h10, "R6 queue4 pending before collision");
        wr(A_IEL, 32'h18);
        cnt_a[3] = 0; apply();
        wr(A_PNL, 32'h18);
        rd(A_PNL, 32'h08, "R9 set wins over clear");
        check("R10 irq_lo high after collision", {31'b0, irq_lo}, 32'h1);
        wr(A_PNL, 32'h08);
        rd(A_PNL, 32'h0, "R8 final clear");
        check("R10 irq_lo low when none pending", {31'b0, irq_lo}, 32'h0);

        // R7: high queues raise on nearly-empty only
        wr(A_IEL, 32'h0);
        for (int j = 0; j < NUM_HI; j++) begin
            cnt_a[NUM_LO+j] = 10; ne_a[NUM_LO+j] = 3;
        end
        apply();
        for (int j = 0; j < NUM_HI; j++) begin
            wr(A_IEH, 32'h1 << j);
            tick();
            wr(A_PNH, 32'hff);
            cnt_a[NUM_LO+j] = 2; apply(); tick();
            rd(A_PNH, 32'h1 << j, "R7 high queue fires on nearly-empty");
            check("R10 irq_hi high", {31'b0, irq_hi}, 32'h1);
            cnt_a[NUM_LO+j] = 10; apply(); tick();
            rd(A_PNH, 32'h1 << j, "R7 leaving nearly-empty adds nothing");
            wr(A_PNH, 32'hff);
            check("R10 irq_hi low after clear", {31'b0, irq_hi}, 32'h0);
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule